// File: doc/BRIEF.md
# Acquisition Card I/O Register Decoder

This block sits between an 8-bit-write, 16-bit-read I/O bus and the control and data paths of a five-channel sampling card. It turns bus writes into a small set of control registers: the FIFO reset line, the FIFO clock enable, the trigger mode and the sample clock divisor. It turns bus reads into 16-bit read words: a sample from one channel's FIFO, the trigger status or the FIFO half-full flags.

Each channel's sample word sits at its own even address. When that address is read, the block raises that channel's FIFO read strobe and pulls its output enable low, so the FIFO presents its next word and then advances. The FIFOs and the acquisition timing live outside the block.

All bus strobes are active low and sampled on the system clock. A write takes effect when its strobe returns high. The read word and the per-channel strobes are registered and appear one clock after the read strobe is sampled low.

Top module: `daq_bus_regs`

## Requirements
- R1: A synchronous active-high reset sets the FIFO reset output low (asserted), the FIFO clock enable low, trigger mode and divisor to zero, the read word to zero, all FIFO read strobes low and all output enables high.
- R2: A write to address 0x301 with data 0x11 drives the FIFO reset output low, and with data 0x12 drives it high. Any other data value written there leaves it unchanged.
- R3: A write to address 0x302 loads data bit 0 into the FIFO clock enable.
- R4: A write to address 0x304 loads all 8 data bits into the trigger mode. A write to address 0x305 loads all 8 data bits into the clock divisor.
- R5: A write changes a register only when the write strobe rises. The new value is visible one clock after the first cycle in which the strobe is sampled high. While the strobe is still low, the register holds its old value.
- R6: Writes to any other address, including the read-only addresses 0x303, 0x309 and 0x306 to 0x30E, change no register.
- R7: Reading channel i (i = 0..4) at address 0x306 + 2*i returns that channel's 12-bit sample in bits 11:0 of the read word, with bits 15:12 zero. The word appears one clock after the read strobe is sampled low.
- R8: While channel i's address is being read, only that channel's FIFO read strobe is high and only its output enable is low, with one clock of latency. Otherwise all read strobes are low and all output enables are high.
- R9: A read of 0x303 returns the trigger status in bit 0. A read of 0x309 returns channel i's half-full flag in bit i. All other bits are zero.
- R10: The read word is zero one clock after any cycle in which the read strobe is high, and after a read of an address with no read function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_ior_n | input | 1 | Read strobe, active low |
| bus_iow_n | input | 1 | Write strobe, active low |
| bus_rdata | output | 16 | Registered read word |
| chan_sample | input | 60 | Per-channel FIFO output words, channel i in bits 12*i+11 to 12*i |
| trig_status | input | 1 | Trigger status level |
| fifo_half | input | 5 | Per-channel FIFO half-full flags |
| fifo_rst_n | output | 1 | FIFO reset, active low |
| fifo_clk_en | output | 1 | FIFO clock enable |
| trig_mode | output | 8 | Trigger mode register |
| clk_div | output | 8 | Sample clock divisor register |
| fifo_rd | output | 5 | Per-channel FIFO read strobe, active high |
| fifo_oe_n | output | 5 | Per-channel FIFO output enable, active low |

## Verification
The assertions assume that both strobes are synchronous to the clock and never low in the same cycle, and that the address and write data stay steady for every cycle a strobe is low. The stimulus drives every input on the falling clock edge. It holds the address and data for the whole strobe-low window and raises a strobe before it changes the address, so the captured write target and the channel decode always describe a single bus cycle. The FIFO model advances its word only on a cycle where the block's read strobe is high. Because of this, consecutive reads of the same channel show the strobe pulse and the sample latch together.

// File: rtl/daq_bus_pkg.sv
package daq_bus_pkg;
  // Offsets from the card's base I/O address. The channel data words use
  // even offsets starting at OFS_CH0; the odd offset 9 in between holds flags.
  localparam int unsigned OFS_FIFO_RST  = 1;
  localparam int unsigned OFS_CLK_EN    = 2;
  localparam int unsigned OFS_TRIG_STAT = 3;
  localparam int unsigned OFS_TRIG_MODE = 4;
  localparam int unsigned OFS_DIV       = 5;
  localparam int unsigned OFS_CH0       = 6;
  localparam int unsigned CH_STRIDE     = 2;
  localparam int unsigned OFS_HALF      = 9;

  // Command codes accepted at the FIFO reset address
  localparam logic [7:0] CODE_RST_ON  = 8'h11;
  localparam logic [7:0] CODE_RST_OFF = 8'h12;

  typedef enum logic [2:0] {
    WT_NONE,
    WT_FIFO_RST,
    WT_CLK_EN,
    WT_TRIG_MODE,
    WT_DIV
  } wr_target_e;
endpackage

// File: rtl/daq_wr_capture.sv
module daq_wr_capture
  import daq_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BASE   = 'h300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              iow_n,
  output logic              commit,
  output wr_target_e        target,
  output logic [DATA_W-1:0] cap_data
);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(BASE + OFS_FIFO_RST);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(BASE + OFS_CLK_EN);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(BASE + OFS_TRIG_MODE);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(BASE + OFS_DIV);

  logic              iow_q;
  logic [ADDR_W-1:0] cap_addr;

  // Hold the last address/data seen with the strobe low; commit on its rise
  always_ff @(posedge clk) begin
    if (rst) begin
      iow_q    <= 1'b1;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      iow_q <= iow_n;
      if (!iow_n) begin
        cap_addr <= addr;
        cap_data <= wdata;
      end
    end
  end

  assign commit = iow_n & ~iow_q;

  always_comb begin
    target = WT_NONE;
    if (cap_addr == A_RST)  target = WT_FIFO_RST;
    if (cap_addr == A_EN)   target = WT_CLK_EN;
    if (cap_addr == A_MODE) target = WT_TRIG_MODE;
    if (cap_addr == A_DIV)  target = WT_DIV;
  end

  AST_NO_COMMIT_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    !iow_n |-> !commit); // R5
endmodule

// File: rtl/daq_ctrl_regs.sv
module daq_ctrl_regs
  import daq_bus_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MODE_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  wr_target_e        target,
  input  logic [DATA_W-1:0] cap_data,
  output logic              fifo_rst_n,
  output logic              clk_en,
  output logic [MODE_W-1:0] trig_mode,
  output logic [DIV_W-1:0]  clk_div
);
  localparam logic [DATA_W-1:0] K_ON  = DATA_W'(CODE_RST_ON);
  localparam logic [DATA_W-1:0] K_OFF = DATA_W'(CODE_RST_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_rst_n <= 1'b0;
      clk_en     <= 1'b0;
      trig_mode  <= '0;
      clk_div    <= '0;
    end else if (commit) begin
      case (target)
        WT_FIFO_RST: begin
          if (cap_data == K_ON)       fifo_rst_n <= 1'b0;
          else if (cap_data == K_OFF) fifo_rst_n <= 1'b1;
        end
        WT_CLK_EN:    clk_en    <= cap_data[0];
        WT_TRIG_MODE: trig_mode <= cap_data[MODE_W-1:0];
        WT_DIV:       clk_div   <= cap_data[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable({fifo_rst_n, clk_en, trig_mode, clk_div})); // R5
  AST_RST_ON_CODE: assert property (@(posedge clk) disable iff (rst)
    (commit && target == WT_FIFO_RST && cap_data == K_ON) |=> !fifo_rst_n); // R2
  AST_RST_OFF_CODE: assert property (@(posedge clk) disable iff (rst)
    (commit && target == WT_FIFO_RST && cap_data == K_OFF) |=> fifo_rst_n); // R2
  AST_UNMAPPED_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (commit && target == WT_NONE) |=> $stable({fifo_rst_n, clk_en, trig_mode, clk_div})); // R6
endmodule

// File: rtl/daq_rd_path.sv
module daq_rd_path
  import daq_bus_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned NCH      = 5,
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned RD_W     = 16,
  parameter int unsigned BASE     = 'h300
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ior_n,
  input  logic [NCH*SAMPLE_W-1:0] chan_sample,
  input  logic                    trig_status,
  input  logic [NCH-1:0]          fifo_half,
  output logic [RD_W-1:0]         rdata,
  output logic [NCH-1:0]          fifo_rd,
  output logic [NCH-1:0]          fifo_oe_n
);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(BASE + OFS_TRIG_STAT);
  localparam logic [ADDR_W-1:0] A_HALF = ADDR_W'(BASE + OFS_HALF);

  logic [NCH-1:0]  hit;
  logic [RD_W-1:0] rd_next;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam logic [ADDR_W-1:0] A_CH = ADDR_W'(BASE + OFS_CH0 + g * CH_STRIDE);
    assign hit[g] = !ior_n && (addr == A_CH);

    always_ff @(posedge clk) begin
      if (rst) begin
        fifo_rd[g]   <= 1'b0;
        fifo_oe_n[g] <= 1'b1;
      end else begin
        fifo_rd[g]   <= hit[g];
        fifo_oe_n[g] <= ~hit[g];
      end
    end

    AST_CHAN_STROBE: assert property (@(posedge clk) disable iff (rst)
      hit[g] |=> (fifo_rd[g] && !fifo_oe_n[g])); // R8
  end

  always_comb begin
    rd_next = '0;
    if (!ior_n) begin
      if (addr == A_TRIG) rd_next = RD_W'(trig_status);
      if (addr == A_HALF) rd_next = RD_W'(fifo_half);
      for (int i = 0; i < NCH; i++)
        if (hit[i]) rd_next = RD_W'(chan_sample[i*SAMPLE_W +: SAMPLE_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fifo_rd)); // R8
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (rst)
    ior_n |=> (fifo_rd == '0 && fifo_oe_n == '1)); // R8
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ior_n |=> (rdata == '0)); // R10
  AST_SAMPLE_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (|fifo_rd) |-> (rdata[RD_W-1:SAMPLE_W] == '0)); // R7
endmodule

// File: rtl/daq_bus_regs.sv
module daq_bus_regs
  import daq_bus_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RD_W     = 16,
  parameter int unsigned NCH      = 5,
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned MODE_W   = 8,
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned BASE     = 'h300
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_ior_n,
  input  logic                    bus_iow_n,
  output logic [RD_W-1:0]         bus_rdata,
  input  logic [NCH*SAMPLE_W-1:0] chan_sample,
  input  logic                    trig_status,
  input  logic [NCH-1:0]          fifo_half,
  output logic                    fifo_rst_n,
  output logic                    fifo_clk_en,
  output logic [MODE_W-1:0]       trig_mode,
  output logic [DIV_W-1:0]        clk_div,
  output logic [NCH-1:0]          fifo_rd,
  output logic [NCH-1:0]          fifo_oe_n
);
  logic              commit;
  wr_target_e        target;
  logic [DATA_W-1:0] cap_data;

  daq_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)) u_wr (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .iow_n(bus_iow_n),
    .commit(commit), .target(target), .cap_data(cap_data)
  );

  daq_ctrl_regs #(.DATA_W(DATA_W), .MODE_W(MODE_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .commit(commit), .target(target), .cap_data(cap_data),
    .fifo_rst_n(fifo_rst_n), .clk_en(fifo_clk_en), .trig_mode(trig_mode),
    .clk_div(clk_div)
  );

  daq_rd_path #(.ADDR_W(ADDR_W), .NCH(NCH), .SAMPLE_W(SAMPLE_W), .RD_W(RD_W),
                .BASE(BASE)) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr), .ior_n(bus_ior_n),
    .chan_sample(chan_sample), .trig_status(trig_status), .fifo_half(fifo_half),
    .rdata(bus_rdata), .fifo_rd(fifo_rd), .fifo_oe_n(fifo_oe_n)
  );

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!bus_ior_n && !bus_iow_n)); // R5
endmodule

// File: tb/sim_daq_bus_regs.sv
module sim_daq_bus_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_ior_n, bus_iow_n;
  logic [15:0] bus_rdata;
  logic [59:0] chan_sample;
  logic        trig_status;
  logic [4:0]  fifo_half;
  logic        fifo_rst_n, fifo_clk_en;
  logic [7:0]  trig_mode, clk_div;
  logic [4:0]  fifo_rd, fifo_oe_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  daq_bus_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_rdata(bus_rdata),
    .chan_sample(chan_sample), .trig_status(trig_status), .fifo_half(fifo_half),
    .fifo_rst_n(fifo_rst_n), .fifo_clk_en(fifo_clk_en), .trig_mode(trig_mode),
    .clk_div(clk_div), .fifo_rd(fifo_rd), .fifo_oe_n(fifo_oe_n)
  );

  // FIFO model: each channel advances its word after a cycle with its read strobe high
  logic [11:0] fifo_word [5];
  always @(posedge clk)
    for (int i = 0; i < 5; i++)
      if (rst) fifo_word[i] <= 12'hF00 + 12'(i * 'h11);
      else if (fifo_rd[i]) fifo_word[i] <= fifo_word[i] + 12'h1A7;
  always_comb
    for (int i = 0; i < 5; i++) chan_sample[i*12 +: 12] = fifo_word[i];

  // Bench-side expectations
  logic        e_rst_n, e_en;
  logic [7:0]  e_mode, e_div;
  logic [11:0] e_word [5];

  // Scoreboard queues for the read path
  logic [15:0] q_data [$];
  logic [4:0]  q_rd   [$];
  string       q_tag  [$];

  logic [15:0] m_data;
  logic [4:0]  m_rd;
  string       m_tag;
  always @(posedge clk) begin
    #1;
    if (q_tag.size() != 0) begin
      m_data = q_data.pop_front();
      m_rd   = q_rd.pop_front();
      m_tag  = q_tag.pop_front();
      checks++;
      if (bus_rdata !== m_data || fifo_rd !== m_rd || fifo_oe_n !== ~m_rd) begin
        fails++;
        $display("FAIL %s: rdata=%h rd=%b oe_n=%b expected rdata=%h rd=%b oe_n=%b",
                 m_tag, bus_rdata, fifo_rd, fifo_oe_n, m_data, m_rd, ~m_rd);
      end
    end
  end

  task automatic check_regs(input string tag);
    checks++;
    if (fifo_rst_n !== e_rst_n || fifo_clk_en !== e_en ||
        trig_mode !== e_mode || clk_div !== e_div) begin
      fails++;
      $display("FAIL %s: rst_n=%b en=%b mode=%h div=%h expected %b %b %h %h",
               tag, fifo_rst_n, fifo_clk_en, trig_mode, clk_div,
               e_rst_n, e_en, e_mode, e_div);
    end
  endtask

  task automatic model_reset();
    e_rst_n = 1'b0; e_en = 1'b0; e_mode = 8'h00; e_div = 8'h00;
    for (int i = 0; i < 5; i++) e_word[i] = 12'hF00 + 12'(i * 'h11);
  endtask

  // Hold the write strobe low for two cycles, check nothing moved, then release
  task automatic bus_write(input logic [9:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_iow_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_regs({tag, " R5 pending"});
    bus_iow_n = 1'b1;
    @(negedge clk);
    case (a)
      10'h301: if (d == 8'h11) e_rst_n = 1'b0; else if (d == 8'h12) e_rst_n = 1'b1;
      10'h302: e_en = d[0];
      10'h304: e_mode = d;
      10'h305: e_div = d;
      default: ;
    endcase
    check_regs(tag);
  endtask

  task automatic bus_read(input logic [9:0] a, input logic [15:0] ed,
                          input logic [4:0] er, input string tag);
    @(negedge clk);
    bus_addr = a; bus_ior_n = 1'b0;
    q_data.push_back(ed); q_rd.push_back(er); q_tag.push_back(tag);
    @(negedge clk);
    bus_ior_n = 1'b1;
    q_data.push_back(16'h0000); q_rd.push_back(5'b00000);
    q_tag.push_back({tag, " R8 R10 idle after"});
    @(negedge clk);
    bus_addr = 10'h000;
  endtask

  task automatic read_chan(input int ch);
    bus_read(10'(10'h306 + ch * 2), {4'h0, e_word[ch]}, 5'(1 << ch),
             $sformatf("R7 R8 channel %0d", ch));
    e_word[ch] = e_word[ch] + 12'h1A7;
  endtask

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_ior_n = 1'b1; bus_iow_n = 1'b1;
    trig_status = 1'b0; fifo_half = '0;
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_regs("R1 reset registers");
    checks++;
    if (bus_rdata !== 16'h0 || fifo_rd !== 5'b0 || fifo_oe_n !== 5'h1F) begin
      fails++;
      $display("FAIL R1 reset outputs: rdata=%h rd=%b oe_n=%b expected 0000 00000 11111",
               bus_rdata, fifo_rd, fifo_oe_n);
    end

    bus_write(10'h301, 8'h12, "R2 release fifo reset");
    bus_write(10'h301, 8'h33, "R2 other code ignored");
    bus_write(10'h301, 8'h11, "R2 assert fifo reset");
    bus_write(10'h301, 8'h13, "R2 near code ignored");
    bus_write(10'h301, 8'h12, "R2 release again");
    bus_write(10'h302, 8'hFF, "R3 clock enable on");
    bus_write(10'h302, 8'hFE, "R3 bit0 low disables");
    bus_write(10'h302, 8'h01, "R3 clock enable bit0");
    bus_write(10'h304, 8'hA5, "R4 trigger mode");
    bus_write(10'h305, 8'h3C, "R4 divisor");
    bus_write(10'h305, 8'hFF, "R4 divisor all ones");
    bus_write(10'h303, 8'h5A, "R6 write to trigger status");
    bus_write(10'h309, 8'h00, "R6 write to half flags");
    bus_write(10'h306, 8'h77, "R6 write to channel 0");
    bus_write(10'h300, 8'h11, "R6 write below base");
    bus_write(10'h314, 8'h12, "R6 write far address");

    for (int ch = 0; ch < 5; ch++) read_chan(ch);
    read_chan(4);
    read_chan(4);
    read_chan(2);

    trig_status = 1'b0;
    bus_read(10'h303, 16'h0000, 5'b0, "R9 trigger status low");
    trig_status = 1'b1;
    bus_read(10'h303, 16'h0001, 5'b0, "R9 trigger status high");
    fifo_half = 5'b10110;
    bus_read(10'h309, 16'h0016, 5'b0, "R9 half flags");
    fifo_half = 5'b01001;
    bus_read(10'h309, 16'h0009, 5'b0, "R9 half flags other");
    bus_read(10'h300, 16'h0000, 5'b0, "R10 unassigned base");
    bus_read(10'h307, 16'h0000, 5'b0, "R10 odd between channels");
    bus_read(10'h301, 16'h0000, 5'b0, "R10 write-only address");
    bus_read(10'h310, 16'h0000, 5'b0, "R10 past last channel");

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check_regs("R1 second reset");
    read_chan(1);

    repeat (4) @(negedge clk);
    if (q_tag.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", q_tag.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule